// File: doc/BRIEF.md
# Destination address unicast filter

This block sits in the receive path of an Ethernet port. For each incoming frame it decides whether the destination MAC address is accepted. When it is, the block also names the receive queue the frame is steered to. It holds the station address and a small unicast steering table. It also holds a control word with a unicast-promiscuous enable and a default queue number. The multicast filter tables are kept here as plain storage: software can write them and reset clears them, but the lookup does not use them.

Software programs the block through a simple word-addressed register port with a single-cycle write strobe and combinational read data. The receive side presents a 48-bit destination address with a valid strobe. The verdict (valid, accept, queue) appears on registered outputs one clock later. Steering uses a table of byte-wide entries, four to a 32-bit word. The entry is chosen by the low nibble of the last address byte. In each entry, bit 0 is the accept flag and bits [3:1] are the queue number.

Top module: `da_ucast_filter`

## Requirements
- R1: After reset, every register and table word reads 0, and `res_valid` and `res_accept` are 0.
- R2: Address byte 0 is the first byte, and `da[47:40]` carries it. The station-high register (word address 0x00) holds bytes 0..3, with byte 0 in bits [31:24]. The station-low register (0x01) holds byte 4 in bits [15:8] and byte 5 in bits [7:0]. Its bits [31:16] are not stored and read as 0.
- R3: The steering entry for a lookup has index n = `da[3:0]`, the low nibble of the last byte. It lives in unicast table word n/4, at word address 0x04 + n/4, in bits [8*(n%4)+7 : 8*(n%4)].
- R4: Unless promiscuous mode accepts it, a frame is accepted only when all 48 bits of `da` equal the station address and bit 0 of the indexed entry is 1. The queue is then entry bits [3:1]. A rejected frame reports queue 0.
- R5: An entry whose byte lane has been written to zero rejects the station address.
- R6: The control register (0x02) holds bit 0 as the promiscuous enable and bits [3:1] as the default queue. With the enable at 1, a unicast frame that is not accepted under R4 is accepted to the default queue. An R4 hit keeps its own entry queue. With the enable at 0, non-matching frames are rejected.
- R7: A destination with the group bit set (`da[40]`, bit 0 of byte 0) is never accepted, whether or not promiscuous mode is on and whether or not it equals the station address.
- R8: `res_valid` is 1 exactly in the cycle after a cycle with `da_valid` = 1. Back-to-back lookups each get their own result, and with no lookup `res_accept` is 0.
- R9: Two multicast tables of MC_WORDS words each (64 by default) are readable and writable. The special table is at word addresses MC_WORDS..2*MC_WORDS-1 and the other table at 2*MC_WORDS..3*MC_WORDS-1. Both are cleared by reset, and a zero write clears a word.
- R10: Every mapped register reads back what was written (within its stored bits). Unmapped addresses read 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Word address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| da_valid | input | 1 | Destination address present this cycle |
| da | input | 48 | Destination address, byte 0 in [47:40] |
| res_valid | output | 1 | Verdict valid (one cycle after `da_valid`) |
| res_accept | output | 1 | Frame accepted |
| res_queue | output | 3 | Target receive queue, 0 when rejected |

## Verification
The assertions watch the verdict timing on every cycle: each lookup yields exactly one valid result one clock later, and an idle cycle yields none. On every cycle they also check that a group-addressed frame is never accepted, that a rejected verdict carries queue 0, and that a non-matching address is rejected while promiscuous mode is off. Only the bench's scenarios can show the register layout, the table indexing by the last nibble and the byte-lane placement. The same holds for the queue chosen by an exact hit versus the promiscuous default, for clearing an entry, and for the multicast storage and unmapped addresses.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
   localparam int WORD_W  = 32;
   localparam int ENTRY_W = 8;
   localparam int QUEUE_W = 3;
   localparam int DA_W    = 48;

   // word addresses of the fixed registers
   localparam int STA_HI_A = 0;
   localparam int STA_LO_A = 1;
   localparam int CTRL_A   = 2;
   localparam int UC_BASE  = 4;

   // one steering entry: accept flag in bit 0, queue above it
   typedef struct packed {
      logic [ENTRY_W-QUEUE_W-2:0] spare;
      logic [QUEUE_W-1:0]         queue;
      logic                       accept;
   } uc_entry_t;
endpackage

// File: rtl/dafilt_regs.sv
module dafilt_regs
   import dafilt_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int MC_WORDS   = 64,
   parameter int UC_ENTRIES = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_we,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [WORD_W-1:0]             reg_wdata,
   output logic [WORD_W-1:0]             reg_rdata,
   output logic [DA_W-1:0]               station,
   output logic                          promisc,
   output logic [QUEUE_W-1:0]            dflt_q,
   output logic [UC_ENTRIES*ENTRY_W-1:0] uc_flat
);
   localparam int UC_WORDS = UC_ENTRIES * ENTRY_W / WORD_W;
   localparam int MC_AW    = $clog2(MC_WORDS);
   localparam int SEL_W    = ADDR_W - MC_AW;
   localparam int N_MC     = 2;

   logic [WORD_W-1:0] sta_hi_q;
   logic [15:0]       sta_lo_q;
   logic              prom_q;
   logic [QUEUE_W-1:0] dq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sta_hi_q <= '0;
         sta_lo_q <= '0;
         prom_q   <= 1'b0;
         dq_q     <= '0;
      end else if (reg_we) begin
         if (reg_addr == ADDR_W'(STA_HI_A)) sta_hi_q <= reg_wdata;
         if (reg_addr == ADDR_W'(STA_LO_A)) sta_lo_q <= reg_wdata[15:0];
         if (reg_addr == ADDR_W'(CTRL_A)) begin
            prom_q <= reg_wdata[0];
            dq_q   <= reg_wdata[QUEUE_W:1];
         end
      end
   end

   assign station = {sta_hi_q, sta_lo_q};
   assign promisc = prom_q;
   assign dflt_q  = dq_q;

   // unicast steering words, one register per word
   for (genvar w = 0; w < UC_WORDS; w++) begin : g_uc
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            word_q <= '0;
         else if (reg_we && reg_addr == ADDR_W'(UC_BASE + w))
            word_q <= reg_wdata;
      end
      assign uc_flat[w*WORD_W +: WORD_W] = word_q;
   end

   // multicast tables: storage only
   logic [WORD_W-1:0] mc_rd  [N_MC];
   logic              mc_sel [N_MC];
   for (genvar t = 0; t < N_MC; t++) begin : g_mc
      logic [WORD_W-1:0] mem [MC_WORDS];
      assign mc_sel[t] = (reg_addr[ADDR_W-1:MC_AW] == SEL_W'(t + 1));
      assign mc_rd[t]  = mem[reg_addr[MC_AW-1:0]];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < MC_WORDS; i++) mem[i] <= '0;
         end else if (reg_we && mc_sel[t]) begin
            mem[reg_addr[MC_AW-1:0]] <= reg_wdata;
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(STA_HI_A)) reg_rdata = sta_hi_q;
      if (reg_addr == ADDR_W'(STA_LO_A)) reg_rdata = WORD_W'(sta_lo_q);
      if (reg_addr == ADDR_W'(CTRL_A))   reg_rdata = WORD_W'({dq_q, prom_q});
      for (int w = 0; w < UC_WORDS; w++)
         if (reg_addr == ADDR_W'(UC_BASE + w)) reg_rdata = uc_flat[w*WORD_W +: WORD_W];
      for (int t = 0; t < N_MC; t++)
         if (mc_sel[t]) reg_rdata = mc_rd[t];
   end
endmodule

// File: rtl/dafilt_match.sv
module dafilt_match
   import dafilt_pkg::*;
#(
   parameter int UC_ENTRIES = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          da_valid,
   input  logic [DA_W-1:0]               da,
   input  logic [DA_W-1:0]               station,
   input  logic                          promisc,
   input  logic [QUEUE_W-1:0]            dflt_q,
   input  logic [UC_ENTRIES*ENTRY_W-1:0] uc_flat,
   output logic                          res_valid,
   output logic                          res_accept,
   output logic [QUEUE_W-1:0]            res_queue
);
   localparam int IDX_W   = $clog2(UC_ENTRIES);
   localparam int GROUP_B = DA_W - 8;

   logic [IDX_W-1:0]   idx;
   uc_entry_t          ent;
   logic               is_group, exact, uc_hit, nxt_acc;
   logic [QUEUE_W-1:0] nxt_q;

   assign idx      = da[IDX_W-1:0];
   assign ent      = uc_entry_t'(uc_flat[int'(idx)*ENTRY_W +: ENTRY_W]);
   assign is_group = da[GROUP_B];
   assign exact    = (da == station);
   assign uc_hit   = exact && ent.accept && !is_group;

   always_comb begin
      nxt_acc = 1'b0;
      nxt_q   = '0;
      if (uc_hit) begin
         nxt_acc = 1'b1;
         nxt_q   = ent.queue;
      end else if (promisc && !is_group) begin
         nxt_acc = 1'b1;
         nxt_q   = dflt_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid  <= 1'b0;
         res_accept <= 1'b0;
         res_queue  <= '0;
      end else begin
         res_valid  <= da_valid;
         res_accept <= da_valid && nxt_acc;
         res_queue  <= da_valid ? nxt_q : '0;
      end
   end

   // R8
   verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      da_valid |=> res_valid);
   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !da_valid |=> (!res_valid && !res_accept));
   // R7
   group_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && da[GROUP_B]) |=> !res_accept);
   // R6
   strict_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (da_valid && !promisc && (da != station)) |=> !res_accept);
   // R4
   reject_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !res_accept |-> (res_queue == '0));
endmodule

// File: rtl/da_ucast_filter.sv
module da_ucast_filter
   import dafilt_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int MC_WORDS   = 64,
   parameter int UC_ENTRIES = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              da_valid,
   input  logic [47:0]       da,
   output logic              res_valid,
   output logic              res_accept,
   output logic [2:0]        res_queue
);
   localparam int UC_BITS = UC_ENTRIES * ENTRY_W;

   if (UC_ENTRIES != 4 && UC_ENTRIES != 8 && UC_ENTRIES != 16) begin : g_bad_entries
      $error("UC_ENTRIES must be 4, 8 or 16");
   end
   if (MC_WORDS < 8 || (MC_WORDS & (MC_WORDS - 1)) != 0) begin : g_bad_mc
      $error("MC_WORDS must be a power of two of at least 8");
   end
   if (3 * MC_WORDS > (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too narrow for the multicast tables");
   end

   logic [DA_W-1:0]    station;
   logic               promisc;
   logic [QUEUE_W-1:0] dflt_q;
   logic [UC_BITS-1:0] uc_flat;

   dafilt_regs #(
      .ADDR_W(ADDR_W), .MC_WORDS(MC_WORDS), .UC_ENTRIES(UC_ENTRIES)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .station(station),
      .promisc(promisc), .dflt_q(dflt_q), .uc_flat(uc_flat)
   );

   dafilt_match #(.UC_ENTRIES(UC_ENTRIES)) u_match (
      .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da(da),
      .station(station), .promisc(promisc), .dflt_q(dflt_q), .uc_flat(uc_flat),
      .res_valid(res_valid), .res_accept(res_accept), .res_queue(res_queue)
   );
endmodule

// File: tb/da_ucast_filter_bench.sv
`timescale 1ns/1ps
module da_ucast_filter_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        da_valid = 1'b0;
   logic [47:0] da = '0;
   logic        res_valid, res_accept;
   logic [2:0]  res_queue;
   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   localparam logic [47:0] STA = 48'h0211_2233_445B;

   always #2.5 clk = ~clk;

   da_ucast_filter u_da_ucast_filter (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .da_valid(da_valid), .da(da),
      .res_valid(res_valid), .res_accept(res_accept), .res_queue(res_queue)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(tag, reg_rdata, exp);
   endtask

   task automatic lookup(input logic [47:0] d, input logic acc, input logic [2:0] q,
                         input string tag);
      @(negedge clk);
      da_valid = 1'b1; da = d;
      @(negedge clk);
      da_valid = 1'b0;
      check({tag, " valid"}, res_valid, 1'b1);
      check({tag, " accept"}, res_accept, acc);
      check({tag, " queue"}, res_queue, q);
   endtask

   task automatic t_reset;
      rd_chk(8'h00, 0, "R1 station high");
      rd_chk(8'h01, 0, "R1 station low");
      rd_chk(8'h02, 0, "R1 control");
      for (int w = 4; w < 8; w++) rd_chk(8'(w), 0, "R1 unicast word");
      rd_chk(8'h40, 0, "R1 special mc");
      rd_chk(8'hBF, 0, "R1 other mc");
      check("R1 res_valid", res_valid, 0);
      check("R1 res_accept", res_accept, 0);
   endtask

   task automatic t_station;
      wr(8'h00, 32'h0211_2233);
      wr(8'h01, 32'hFFFF_445B);
      rd_chk(8'h00, 32'h0211_2233, "R2 R10 station high");
      rd_chk(8'h01, 32'h0000_445B, "R2 station low upper bits");
   endtask

   task automatic t_exact;
      // index B -> word 2 (addr 6), lane 3; entry 0x0B = accept, queue 5
      wr(8'h06, 32'h0B00_0000);
      rd_chk(8'h06, 32'h0B00_0000, "R10 unicast word");
      lookup(STA, 1, 3'd5, "R2 R3 R4 exact hit idx B");
      wr(8'h06, 32'h000B_0000);
      lookup(STA, 0, 0, "R3 wrong lane");
      wr(8'h06, 32'h0);
      wr(8'h07, 32'h0B00_0000);
      lookup(STA, 0, 0, "R3 wrong word");
      // index 0: word 0 lane 0, entry accept queue 3
      wr(8'h01, 32'h0000_4490);
      wr(8'h04, 32'h0000_0007);
      lookup(48'h0211_2233_4490, 1, 3'd3, "R3 idx 0");
      // index F: word 3 lane 3, entry accept queue 7
      wr(8'h01, 32'h0000_44AF);
      wr(8'h07, 32'h0F00_0000);
      lookup(48'h0211_2233_44AF, 1, 3'd7, "R3 idx F");
      wr(8'h01, 32'h0000_445B);
      wr(8'h04, 0);
      wr(8'h07, 0);
   endtask

   task automatic t_mismatch;
      wr(8'h06, 32'h0B00_0000);
      lookup(48'h8211_2233_445B, 0, 0, "R4 byte0 differs");
      lookup(48'h0211_2233_444B, 0, 0, "R4 same nibble differs");
      wr(8'h06, 32'h0A00_0000);
      lookup(STA, 0, 0, "R4 accept bit clear");
   endtask

   task automatic t_clear;
      wr(8'h06, 32'h0B0B_0B0B);
      lookup(STA, 1, 3'd5, "R5 before clear");
      wr(8'h06, 32'h000B_0B0B);
      rd_chk(8'h06, 32'h000B_0B0B, "R5 word after clear");
      lookup(STA, 0, 0, "R5 cleared lane");
   endtask

   task automatic t_promisc;
      wr(8'h02, 32'h0000_000D);
      rd_chk(8'h02, 32'h0000_000D, "R6 R10 control");
      lookup(48'h02AA_BBCC_DDEE, 1, 3'd6, "R6 foreign to default");
      wr(8'h06, 32'h0B00_0000);
      lookup(STA, 1, 3'd5, "R6 exact hit wins");
      wr(8'h06, 32'h0);
      lookup(STA, 1, 3'd6, "R6 cleared entry default");
      wr(8'h02, 32'h0000_000C);
      lookup(48'h02AA_BBCC_DDEE, 0, 0, "R6 off rejects");
   endtask

   task automatic t_group;
      wr(8'h02, 32'h0000_000D);
      lookup(48'h03AA_BBCC_DDEE, 0, 0, "R7 group in promisc");
      wr(8'h00, 32'h0111_2233);
      wr(8'h06, 32'h0B00_0000);
      lookup(48'h0111_2233_445B, 0, 0, "R7 group station");
      wr(8'h00, 32'h0211_2233);
      wr(8'h02, 32'h0);
   endtask

   task automatic t_timing;
      @(negedge clk);
      da_valid = 1'b1; da = STA;
      @(negedge clk);
      check("R8 first valid", res_valid, 1);
      check("R8 first accept", res_accept, 1);
      check("R8 first queue", res_queue, 3'd5);
      da = 48'h02AA_BBCC_DDEE;
      @(negedge clk);
      da_valid = 1'b0;
      check("R8 second valid", res_valid, 1);
      check("R8 second accept", res_accept, 0);
      @(negedge clk);
      check("R8 idle valid", res_valid, 0);
      check("R8 idle accept", res_accept, 0);
   endtask

   task automatic t_mc;
      wr(8'h40, 32'hA5A5_0001);
      wr(8'h7F, 32'h0000_1234);
      wr(8'hBF, 32'hDEAD_BEEF);
      rd_chk(8'h40, 32'hA5A5_0001, "R9 special first");
      rd_chk(8'h7F, 32'h0000_1234, "R9 special last");
      rd_chk(8'hBF, 32'hDEAD_BEEF, "R9 other last");
      rd_chk(8'h80, 32'h0, "R9 other first untouched");
      wr(8'h40, 32'h0);
      rd_chk(8'h40, 32'h0, "R9 cleared word");
      wr(8'h03, 32'hFFFF_FFFF);
      wr(8'hC0, 32'hFFFF_FFFF);
      wr(8'h08, 32'hFFFF_FFFF);
      rd_chk(8'h03, 32'h0, "R10 unmapped 03");
      rd_chk(8'hC0, 32'h0, "R10 unmapped C0");
      rd_chk(8'h08, 32'h0, "R10 unmapped 08");
      rd_chk(8'h02, 32'h0, "R10 control untouched");
      rd_chk(8'h00, 32'h0211_2233, "R10 station untouched");
      rd_chk(8'h06, 32'h0B00_0000, "R10 unicast untouched");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset;
      rst_n = 1'b1;
      t_reset;
      t_station;
      t_exact;
      t_mismatch;
      t_clear;
      t_promisc;
      t_group;
      t_timing;
      t_mc;
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule